// File: doc/BRIEF.md
# 16-bit Add/Subtract Flag Unit

This unit carries out the three 16-bit register-pair arithmetic operations of an 8-bit processor core: plain add, add with carry, and subtract with borrow. It takes a destination operand, a source operand, a two-bit operation code and the current 8-bit flag register. It returns the 16-bit result and the new flag register. The sequencer drives the operands together with a one-cycle `start` strobe. The unit captures result and flags on that clock edge and raises `done` for exactly the following cycle. The captured values stay on the outputs until the next accepted strobe.

The half-carry is taken at the boundary between bits 11 and 12, which is the nibble carry of the high byte, and not at bit 4. Plain add changes only the carry-related flags and passes sign, zero and parity/overflow through from the incoming flags. The two carry-using operations rewrite every flag.

Top module: `addsub16_flag_unit`

## Requirements
- R1: Operation code 2'b00 (plain add) gives result = (dst + src) mod 2^16.
- R2: Operation code 2'b01 (add with carry) gives result = (dst + src + C) mod 2^16, where C is bit 0 of `flags_in`.
- R3: Operation code 2'b10 (subtract with borrow) gives result = (dst - src - C) mod 2^16.
- R4: Flag bit 0 (carry) is the carry out of bit 15 for both adds and the borrow for subtract.
- R5: Flag bit 4 (half carry) is bit 12 of the sum, or of the difference, of the low 12 bits of both operands, including the C term for operation codes 01 and 10. For subtract it is therefore the borrow out of bit 11.
- R6: Plain add copies flag bits 7 (sign), 6 (zero) and 2 (parity/overflow) unchanged from `flags_in`.
- R7: Add with carry and subtract with borrow set bit 7 to result bit 15 and bit 6 to 1 exactly when the result is zero. They set bit 2 when the operation overflows as signed two's-complement arithmetic.
- R8: Flag bit 1 (subtract) is 1 after operation 10 and 0 after operations 00 and 01.
- R9: Flag bits 5 and 3 are copies of result bits 13 and 11.
- R10: When `start` is high with a legal code, result and flags are registered on that edge and `done` is high for the next cycle only. Outputs hold their values until the next accepted strobe.
- R11: A strobe with code 2'b11 is ignored: `done` stays low and result and flags keep their previous values.
- R12: While `rst_n` is low, result, flags and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 2 | 00 add, 01 add with carry, 10 subtract with borrow, 11 reserved |
| dst | input | 16 | Destination operand (minuend for subtract) |
| src | input | 16 | Source operand |
| flags_in | input | 8 | Current flag register; bit 0 is the incoming carry |
| result | output | 16 | Registered arithmetic result |
| flags_out | output | 8 | Registered new flag register |
| done | output | 1 | High for the one cycle after an accepted strobe |

## Verification
The bench builds two copies side by side, both with DATA_W = 16. One uses SPLIT_CHAIN = 1, where a low 12-bit slice feeds a 4-bit high slice. The other uses SPLIT_CHAIN = 0, a single flat adder that recovers the half carry from operand and sum bits. Every stimulus is checked against a model written with signed integer arithmetic, so both carry-extraction variants are held to the same half-carry, borrow and overflow values. Directed corner cases cover carry rippling through bit 11, signed overflow in both directions and a zero result with borrow. They are followed by an LFSR sweep over all three operations.

// File: rtl/asf_pkg.sv
package asf_pkg;
   typedef enum logic [1:0] {
      ASF_ADD = 2'b00,
      ASF_ADC = 2'b01,
      ASF_SBC = 2'b10,
      ASF_RSV = 2'b11
   } asf_op_e;

   localparam int FLAG_W = 8;
   localparam int FL_C   = 0;
   localparam int FL_N   = 1;
   localparam int FL_PV  = 2;
   localparam int FL_X   = 3;
   localparam int FL_H   = 4;
   localparam int FL_Y   = 5;
   localparam int FL_Z   = 6;
   localparam int FL_S   = 7;

   // flags carried through unchanged by the plain add
   localparam logic [FLAG_W-1:0] ADD_KEEP_MASK =
      FLAG_W'((1 << FL_S) | (1 << FL_Z) | (1 << FL_PV));
endpackage

// File: rtl/asf_adder_slice.sv
module asf_adder_slice #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   localparam int EXT_W = W + 1;

   logic [EXT_W-1:0] ext;

   assign ext  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
   assign sum  = ext[W-1:0];
   assign cout = ext[W];
endmodule

// File: rtl/asf_datapath.sv
module asf_datapath #(
   parameter int DATA_W      = 16,
   parameter int LO_W        = 12,
   parameter bit SPLIT_CHAIN = 1'b1
) (
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] src,
   input  logic              subtract,
   input  logic              carry_term,
   output logic [DATA_W-1:0] sum,
   output logic              carry,
   output logic              half,
   output logic              ovf
);
   localparam int HI_W = DATA_W - LO_W;
   localparam int MSB  = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic              cin_eff;
   logic              cout_raw;
   logic              half_raw;

   // subtraction as dst + ~src + ~borrow
   assign b_eff   = subtract ? ~src : src;
   assign cin_eff = subtract ? ~carry_term : carry_term;

   generate
      if (SPLIT_CHAIN) begin : g_split
         logic [LO_W-1:0] lo_sum;
         logic [HI_W-1:0] hi_sum;
         logic            lo_cout;

         asf_adder_slice #(.W(LO_W)) u_lo (
            .a    (dst[LO_W-1:0]),
            .b    (b_eff[LO_W-1:0]),
            .cin  (cin_eff),
            .sum  (lo_sum),
            .cout (lo_cout)
         );

         asf_adder_slice #(.W(HI_W)) u_hi (
            .a    (dst[MSB:LO_W]),
            .b    (b_eff[MSB:LO_W]),
            .cin  (lo_cout),
            .sum  (hi_sum),
            .cout (cout_raw)
         );

         assign sum      = {hi_sum, lo_sum};
         assign half_raw = lo_cout;
      end else begin : g_flat
         asf_adder_slice #(.W(DATA_W)) u_full (
            .a    (dst),
            .b    (b_eff),
            .cin  (cin_eff),
            .sum  (sum),
            .cout (cout_raw)
         );

         // carry into bit LO_W recovered from operands and sum
         assign half_raw = dst[LO_W] ^ b_eff[LO_W] ^ sum[LO_W];
      end
   endgenerate

   assign carry = subtract ? ~cout_raw : cout_raw;
   assign half  = subtract ? ~half_raw : half_raw;
   assign ovf   = (dst[MSB] == b_eff[MSB]) && (sum[MSB] != dst[MSB]);
endmodule

// File: rtl/asf_flag_build.sv
module asf_flag_build
   import asf_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  asf_op_e           op,
   input  logic [DATA_W-1:0] sum,
   input  logic              carry,
   input  logic              half,
   input  logic              ovf,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags
);
   localparam int MSB   = DATA_W - 1;
   localparam int Y_SRC = DATA_W - 3;
   localparam int X_SRC = DATA_W - 5;

   logic [FLAG_W-1:0] fresh;
   logic [FLAG_W-1:0] keep;

   always_comb begin
      fresh         = '0;
      fresh[FL_S]   = sum[MSB];
      fresh[FL_Z]   = (sum == '0);
      fresh[FL_Y]   = sum[Y_SRC];
      fresh[FL_H]   = half;
      fresh[FL_X]   = sum[X_SRC];
      fresh[FL_PV]  = ovf;
      fresh[FL_N]   = (op == ASF_SBC);
      fresh[FL_C]   = carry;
   end

   assign keep  = (op == ASF_ADD) ? ADD_KEEP_MASK : '0;
   assign flags = (flags_in & keep) | (fresh & ~keep);
endmodule

// File: rtl/addsub16_flag_unit.sv
module addsub16_flag_unit
   import asf_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter bit SPLIT_CHAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] src,
   input  logic [7:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic [7:0]        flags_out,
   output logic              done
);
   localparam int LO_W = DATA_W - 4;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("addsub16_flag_unit: DATA_W must be a multiple of 8, at least 8");
      end
   endgenerate

   asf_op_e           op_e;
   logic              start_ok;
   logic              use_carry;
   logic [DATA_W-1:0] sum;
   logic              carry, half, ovf;
   logic [FLAG_W-1:0] flags_nx;
   logic [DATA_W-1:0] result_q;
   logic [FLAG_W-1:0] flags_q;
   logic              done_q;

   assign op_e      = asf_op_e'(op);
   assign start_ok  = start && (op_e != ASF_RSV);
   assign use_carry = (op_e != ASF_ADD) && flags_in[FL_C];

   asf_datapath #(
      .DATA_W      (DATA_W),
      .LO_W        (LO_W),
      .SPLIT_CHAIN (SPLIT_CHAIN)
   ) u_dp (
      .dst        (dst),
      .src        (src),
      .subtract   (op_e == ASF_SBC),
      .carry_term (use_carry),
      .sum        (sum),
      .carry      (carry),
      .half       (half),
      .ovf        (ovf)
   );

   asf_flag_build #(.DATA_W(DATA_W)) u_fl (
      .op       (op_e),
      .sum      (sum),
      .carry    (carry),
      .half     (half),
      .ovf      (ovf),
      .flags_in (flags_in),
      .flags    (flags_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         flags_q  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= start_ok;
         if (start_ok) begin
            result_q <= sum;
            flags_q  <= flags_nx;
         end
      end
   end

   assign result    = result_q;
   assign flags_out = flags_q;
   assign done      = done_q;

   a_r10_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> done);
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start_ok));
   a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !start_ok |=> ($stable(result_q) && $stable(flags_q)));
   a_r6_add_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && op_e == ASF_ADD) |=>
         ((flags_q & ADD_KEEP_MASK) == $past(flags_in & ADD_KEEP_MASK)));
   a_r8_sub_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags_q[FL_N] == ($past(op_e) == ASF_SBC)));
   a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(op_e) != ASF_ADD) |-> (flags_q[FL_Z] == (result_q == '0)));
endmodule

// File: tb/addsub16_flag_unit_tb.sv
module addsub16_flag_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [15:0] dst = '0, src = '0;
   logic [7:0]  flags_in = '0;
   logic [15:0] res_a, res_b;
   logic [7:0]  fl_a, fl_b;
   logic        done_a, done_b;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   addsub16_flag_unit #(.DATA_W(16), .SPLIT_CHAIN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst(dst), .src(src),
      .flags_in(flags_in), .result(res_a), .flags_out(fl_a), .done(done_a));

   addsub16_flag_unit #(.DATA_W(16), .SPLIT_CHAIN(1'b0)) u_dut_flat (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst(dst), .src(src),
      .flags_in(flags_in), .result(res_b), .flags_out(fl_b), .done(done_b));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // reference model built on signed/unsigned integer arithmetic
   task automatic model(input logic [1:0] o, input logic [15:0] d, input logic [15:0] s,
                        input logic [7:0] f, output logic [15:0] r, output logic [7:0] fo);
      int c, full, lo, sfull;
      c = (o == 2'b00) ? 0 : int'(f[0]);
      fo = '0;
      if (o == 2'b10) begin
         full  = int'(d) - int'(s) - c;
         lo    = int'(d & 16'hfff) - int'(s & 16'hfff) - c;
         sfull = int'($signed(d)) - int'($signed(s)) - c;
         fo[0] = (full < 0);
         fo[4] = (lo < 0);
         fo[1] = 1'b1;
      end else begin
         full  = int'(d) + int'(s) + c;
         lo    = int'(d & 16'hfff) + int'(s & 16'hfff) + c;
         sfull = int'($signed(d)) + int'($signed(s)) + c;
         fo[0] = (full >= 65536);
         fo[4] = (lo >= 4096);
      end
      r = full[15:0];
      fo[5] = r[13];
      fo[3] = r[11];
      if (o == 2'b00) begin
         fo[7] = f[7]; fo[6] = f[6]; fo[2] = f[2];
      end else begin
         fo[7] = r[15];
         fo[6] = (r == 16'h0);
         fo[2] = (sfull > 32767) || (sfull < -32768);
      end
   endtask

   task automatic run_op(input logic [1:0] o, input logic [15:0] d, input logic [15:0] s,
                         input logic [7:0] f);
      logic [15:0] er; logic [7:0] ef;
      string rq;
      model(o, d, s, f, er, ef);
      rq = (o == 2'b00) ? "R1" : (o == 2'b01) ? "R2" : "R3";
      @(negedge clk);
      op = o; dst = d; src = s; flags_in = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      dst = ~d; src = ~s; flags_in = ~f;
      chk("R10", "done", 32'(done_a), 1);
      chk("R10", "done flat", 32'(done_b), 1);
      chk(rq, "result", 32'(res_a), 32'(er));
      chk(rq, "result flat", 32'(res_b), 32'(er));
      chk("R4", "carry", 32'(fl_a[0]), 32'(ef[0]));
      chk("R5", "half", 32'(fl_a[4]), 32'(ef[4]));
      chk("R5", "half flat", 32'(fl_b[4]), 32'(ef[4]));
      chk((o == 2'b00) ? "R6" : "R7", "S Z PV", 32'({fl_a[7], fl_a[6], fl_a[2]}),
          32'({ef[7], ef[6], ef[2]}));
      chk("R8", "N", 32'(fl_a[1]), 32'(ef[1]));
      chk("R9", "Y X", 32'({fl_a[5], fl_a[3]}), 32'({ef[5], ef[3]}));
      chk("R4", "flags flat", 32'(fl_b), 32'(ef));
      @(negedge clk);
      chk("R10", "done pulse ends", 32'(done_a), 0);
      chk("R10", "result held", 32'(res_a), 32'(er));
      chk("R10", "flags held", 32'(fl_a), 32'(ef));
   endtask

   task automatic t_reset();
      chk("R12", "result in reset", 32'(res_a), 0);
      chk("R12", "flags in reset", 32'(fl_a), 0);
      chk("R12", "done in reset", 32'(done_a), 0);
   endtask

   task automatic t_add();
      run_op(2'b00, 16'h1234, 16'h4321, 8'h00);
      run_op(2'b00, 16'h0fff, 16'h0001, 8'hc5);   // half carry, keeps S Z PV (R6)
      run_op(2'b00, 16'hffff, 16'h0001, 8'h00);   // carry out, zero flag kept 0 (R6)
      run_op(2'b00, 16'h2800, 16'h0000, 8'hff);   // R9 bits 13 and 11 set
   endtask

   task automatic t_adc();
      run_op(2'b01, 16'h7fff, 16'h0000, 8'h01);   // signed overflow via carry (R7)
      run_op(2'b01, 16'hffff, 16'h0000, 8'h01);   // zero with carry out
      run_op(2'b01, 16'h8000, 16'h8000, 8'h00);   // negative overflow
      run_op(2'b01, 16'h0ffe, 16'h0001, 8'h01);   // half carry from C term (R5)
   endtask

   task automatic t_sbc();
      run_op(2'b10, 16'h0000, 16'h0001, 8'h00);   // borrow everywhere
      run_op(2'b10, 16'h8000, 16'h0001, 8'h00);   // overflow (R7)
      run_op(2'b10, 16'h1000, 16'h0fff, 8'h01);   // zero, half borrow (R5)
      run_op(2'b10, 16'h5555, 16'h1111, 8'h01);
   endtask

   task automatic t_reserved();
      logic [15:0] r0; logic [7:0] f0;
      r0 = res_a; f0 = fl_a;
      @(negedge clk);
      op = 2'b11; dst = 16'habcd; src = 16'h1234; flags_in = 8'hff; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11", "no done on reserved", 32'(done_a), 0);
      chk("R11", "result unchanged", 32'(res_a), 32'(r0));
      chk("R11", "flags unchanged", 32'(fl_a), 32'(f0));
   endtask

   task automatic t_sweep();
      logic [31:0] lf = 32'hace1_2b57;
      for (int i = 0; i < 300; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         run_op(2'(i % 3), lf[15:0], lf[31:16] ^ 16'(i * 40503), lf[7:0] ^ lf[23:16]);
      end
   endtask

   initial begin
      #1;
      @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_add();
      t_adc();
      t_sbc();
      t_reserved();
      t_sweep();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule